// File: doc/BRIEF.md
# Synchronous Byte-Write Memory Core

A small synchronous memory that stores 36-bit words, each split into four 9-bit lanes (eight data bits plus one parity bit per lane). An external sequencer presents a word address on every clock. A write is accepted on the rising edge. A read is flow-through: once the address and the select state have been registered on an edge, the stored word is driven combinationally from the array during the following cycle.

Write qualification has two layers. An all-lanes write strobe forces a full-word write. Otherwise the per-lane strobes count only when a lane-gate input is asserted. The device responds only when a three-input select decodes true. The output drive flag depends on an asynchronous output enable, and it is held low for the whole cycle that follows any write edge. A sleep input freezes all clocked state so that the stored contents are retained.

Top module: `bytewrite_sram`

## Requirements
- R1: The core is selected only when `chip_en_n`=0, `sel_hi`=1 and `sel_lo_n`=0 at the rising edge. A deselected edge writes nothing and leaves `drv_en` low for the following cycle.
- R2: With the core selected and `all_wr_n`=0 at the edge, all four lanes of the addressed word are written, whatever `lane_gate_n` and `lane_wr_n` are.
- R3: With `all_wr_n`=1, the per-lane strobes take effect only when `lane_gate_n`=0. Then `lane_wr_n[i]`=0 writes lane i.
- R4: Lane i occupies data bits `8i+7..8i` together with parity bit `32+i` of the 36-bit word, for i = 0..3.
- R5: With `all_wr_n`=1 and `lane_gate_n`=1, an edge writes nothing and is a read, even if `lane_wr_n` is all zero.
- R6: After any edge that writes at least one lane, `drv_en` stays low for the whole following cycle.
- R7: After a selected read edge, `rd_data` shows in the same cycle the word at the registered address. This includes the merge of a partial write made on an earlier edge with the lanes it left unchanged.
- R8: `out_en_n` acts without a clock. While it is 1, `drv_en` is 0. Lowering it during a read cycle raises `drv_en` at once.
- R9: While `drv_en` is 0, `rd_data` is all zeros.
- R10: While `sleep`=1, edges change no state and write nothing, and `drv_en` is 0. After `sleep` returns to 0, the stored words are unchanged.
- R11: After synchronous reset, `drv_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the control state |
| addr | input | ADDR_W | Word address from the sequencer |
| wdata | input | 36 | Write word, four 9-bit lanes |
| chip_en_n | input | 1 | Select term, active low |
| sel_hi | input | 1 | Select term, active high |
| sel_lo_n | input | 1 | Select term, active low |
| all_wr_n | input | 1 | Full-word write strobe, active low |
| lane_gate_n | input | 1 | Enables the per-lane strobes, active low |
| lane_wr_n | input | 4 | Per-lane write strobes, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Freezes clocked state, active high |
| rd_data | output | 36 | Flow-through read word, zero when not driving |
| drv_en | output | 1 | Output drive flag |

## Verification
The hardest case to reach is the asynchronous output enable changing in the middle of a read cycle, with no clock edge in between. The stimulus places the toggle between the falling-edge sample and the next rising edge, and it checks the drive flag directly after each change. A second hard case is proving that a lane was left unchanged. To show this, the test follows each partial write with a read of the same word, so that written and untouched lanes are compared together. It reads back again after deselected writes, gate-blocked writes and sleeping writes.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
    localparam int LANES     = 4;
    localparam int LANE_DATA = 8;
    localparam int WORD_W    = LANES * (LANE_DATA + 1);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_t;

    typedef struct packed {
        logic sel;
        logic wr;
    } cyc_state_t;

    // Bit mask of a word covering the enabled lanes (data byte plus parity bit).
    function automatic word_t lane_mask(input lane_t en);
        word_t m;
        m = '0;
        for (int i = 0; i < LANES; i++) begin
            m[i*LANE_DATA +: LANE_DATA] = {LANE_DATA{en[i]}};
            m[LANES*LANE_DATA + i]      = en[i];
        end
        return m;
    endfunction
endpackage

// File: rtl/sbw_select.sv
module sbw_select (
    input  logic chip_en_n,
    input  logic sel_hi,
    input  logic sel_lo_n,
    output logic sel
);
    assign sel = ~chip_en_n & sel_hi & ~sel_lo_n;
endmodule

// File: rtl/sbw_write_qual.sv
module sbw_write_qual
    import sbw_pkg::*;
(
    input  logic  sel,
    input  logic  all_wr_n,
    input  logic  lane_gate_n,
    input  lane_t lane_wr_n,
    output lane_t we
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign we[i] = sel & (~all_wr_n | (~lane_gate_n & ~lane_wr_n[i]));
    end

    always_comb begin
        if (sel && !all_wr_n)
            a_r2_all_lanes: assert (we == '1) else $error("full-word write missed a lane");
        if (sel && all_wr_n && lane_gate_n)
            a_r5_gate_blocks: assert (we == '0) else $error("lane strobe passed a closed gate");
    end
endmodule

// File: rtl/sbw_array.sv
module sbw_array
    import sbw_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  lane_t             we,
    input  logic [ADDR_W-1:0] waddr,
    input  word_t             wdata,
    input  logic [ADDR_W-1:0] raddr,
    output word_t             rdata
);
    word_t mem [DEPTH];
    word_t mask;

    assign mask = lane_mask(we);

    always_ff @(posedge clk) begin
        if (|we)
            mem[waddr] <= (mem[waddr] & ~mask) | (wdata & mask);
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/bytewrite_sram.sv
module bytewrite_sram
    import sbw_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [35:0]       wdata,
    input  logic              chip_en_n,
    input  logic              sel_hi,
    input  logic              sel_lo_n,
    input  logic              all_wr_n,
    input  logic              lane_gate_n,
    input  logic [3:0]        lane_wr_n,
    input  logic              out_en_n,
    input  logic              sleep,
    output logic [35:0]       rd_data,
    output logic              drv_en
);
    logic              sel;
    lane_t             we_raw, we_gated;
    cyc_state_t        st_q;
    logic [ADDR_W-1:0] addr_q;
    word_t             arr_rd;

    sbw_select u_sel (
        .chip_en_n (chip_en_n),
        .sel_hi    (sel_hi),
        .sel_lo_n  (sel_lo_n),
        .sel       (sel)
    );

    sbw_write_qual u_wq (
        .sel         (sel),
        .all_wr_n    (all_wr_n),
        .lane_gate_n (lane_gate_n),
        .lane_wr_n   (lane_wr_n),
        .we          (we_raw)
    );

    // Sleep and reset block every write edge.
    assign we_gated = (sleep || rst) ? '0 : we_raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            addr_q <= '0;
        end else if (!sleep) begin
            st_q.sel <= sel;
            st_q.wr  <= |we_raw;
            addr_q   <= addr;
        end
    end

    sbw_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk   (clk),
        .we    (we_gated),
        .waddr (addr),
        .wdata (wdata),
        .raddr (addr_q),
        .rdata (arr_rd)
    );

    assign drv_en  = ~out_en_n & st_q.sel & ~st_q.wr & ~sleep;
    assign rd_data = drv_en ? arr_rd : '0;

    a_r6_quiet_after_write: assert property (@(posedge clk) disable iff (rst)
        $past(|we_gated) |-> !drv_en) else $error("drive during write cycle");

    a_r1_quiet_after_deselect: assert property (@(posedge clk) disable iff (rst)
        $past(!(!chip_en_n && sel_hi && !sel_lo_n) && !sleep) |-> !drv_en)
        else $error("drive after deselected edge");

    a_r10_sleep_freezes: assert property (@(posedge clk) disable iff (rst)
        sleep |=> $stable(arr_rd)) else $error("array output moved during sleep");
endmodule

// File: tb/sim_bytewrite_sram.sv
`timescale 1ns/1ps
module sim_bytewrite_sram;
    logic        clk = 0;
    logic        rst = 1;
    logic [3:0]  addr = '0;
    logic [35:0] wdata = '0;
    logic        chip_en_n = 1, sel_hi = 0, sel_lo_n = 1;
    logic        all_wr_n = 1, lane_gate_n = 1;
    logic [3:0]  lane_wr_n = 4'hF;
    logic        out_en_n = 0, sleep = 0;
    logic [35:0] rd_data;
    logic        drv_en;

    int checks = 0, fails = 0;
    bit done = 0;

    typedef struct {
        logic        drv;
        logic [35:0] data;
        string       tag;
    } exp_t;
    exp_t q[$];

    logic [35:0] shadow [16];
    logic        sel_m = 0, wr_m = 0;
    logic [3:0]  addr_m = 0;

    always #10 clk = ~clk;

    bytewrite_sram #(.ADDR_W(4)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .chip_en_n(chip_en_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .all_wr_n(all_wr_n), .lane_gate_n(lane_gate_n), .lane_wr_n(lane_wr_n),
        .out_en_n(out_en_n), .sleep(sleep), .rd_data(rd_data), .drv_en(drv_en)
    );

    task automatic check(input string tag, input logic exp_drv, input logic [35:0] exp_data);
        checks++;
        if (drv_en !== exp_drv || rd_data !== exp_data) begin
            fails++;
            $display("FAIL %s: got drv=%b data=%h, expected drv=%b data=%h",
                     tag, drv_en, rd_data, exp_drv, exp_data);
        end
    endtask

    // Monitor: one expected item per clock, compared at the falling edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, e.drv, e.data);
        end
    end

    // Driver: applies one cycle of stimulus, advances the model, pushes the expectation.
    task automatic cyc(input logic [3:0] a, input logic [35:0] d,
                       input logic ce, input logic s1, input logic s0,
                       input logic aw, input logic lg, input logic [3:0] lw,
                       input logic oe, input logic slp, input string tag);
        exp_t e;
        logic [3:0] lanes;
        logic s;
        @(negedge clk); #2;
        addr = a; wdata = d; chip_en_n = ce; sel_hi = s1; sel_lo_n = s0;
        all_wr_n = aw; lane_gate_n = lg; lane_wr_n = lw; out_en_n = oe; sleep = slp;
        @(posedge clk);
        if (!slp) begin
            s = !ce && s1 && !s0;
            lanes = !s ? 4'h0 : (!aw ? 4'hF : (!lg ? ~lw : 4'h0));
            for (int i = 0; i < 4; i++) begin
                if (lanes[i]) begin
                    shadow[a][i*8 +: 8] = d[i*8 +: 8];
                    shadow[a][32+i]     = d[32+i];
                end
            end
            sel_m = s; wr_m = |lanes; addr_m = a;
        end
        e.drv  = !oe && sel_m && !wr_m && !slp;
        e.data = e.drv ? shadow[addr_m] : 36'h0;
        e.tag  = tag;
        q.push_back(e);
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        cyc(a, 36'h0, 0, 1, 0, 1, 1, 4'hF, 0, 0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout, expected run completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #2;
        rst = 0;
        @(negedge clk); #1;
        check("R11 reset state", 1'b0, 36'h0);

        // R2: full-word writes, lane strobes in various states are irrelevant
        cyc(0, 36'h9_1234_5678, 0, 1, 0, 0, 0, 4'hF, 0, 0, "R2 R6 full write a0");
        cyc(1, 36'h5_0A0B_0C0D, 0, 1, 0, 0, 1, 4'h0, 0, 0, "R2 R6 full write a1");
        cyc(2, 36'hC_CAFE_F00D, 0, 1, 0, 0, 0, 4'hA, 0, 0, "R2 R6 full write a2");
        cyc(3, 36'h3_DEAD_BEEF, 0, 1, 0, 0, 1, 4'hF, 0, 0, "R2 R6 full write a3");
        rd(0, "R7 R2 read a0");
        rd(1, "R7 R2 read a1");
        rd(2, "R7 R2 read a2");
        rd(3, "R7 R2 read a3");

        // R3/R4: single-lane writes and merge on read-back
        cyc(1, 36'hF_AAAA_AAAA, 0, 1, 0, 1, 0, 4'b1110, 0, 0, "R3 R6 lane0 write");
        rd(1, "R4 R7 lane0 merge");
        cyc(1, 36'h4_5555_5555, 0, 1, 0, 1, 0, 4'b1011, 0, 0, "R3 R6 lane2 write");
        rd(1, "R4 R7 lane2 merge");
        cyc(2, 36'h9_1111_2222, 0, 1, 0, 1, 0, 4'b0110, 0, 0, "R3 R6 lanes 0,3 write");
        rd(2, "R4 R7 lanes 0,3 merge");

        // R5: gate closed, strobes ignored, cycle is a read
        cyc(3, 36'h0_0000_0000, 0, 1, 0, 1, 1, 4'h0, 0, 0, "R5 gate closed reads");
        rd(3, "R5 R3 word intact");

        // R1: each select term alone blocks a full write
        cyc(0, 36'hF_FFFF_FFFF, 1, 1, 0, 0, 0, 4'h0, 0, 0, "R1 chip_en_n high");
        cyc(0, 36'hF_FFFF_FFFF, 0, 0, 0, 0, 0, 4'h0, 0, 0, "R1 sel_hi low");
        cyc(0, 36'hF_FFFF_FFFF, 0, 1, 1, 0, 0, 4'h0, 0, 0, "R1 sel_lo_n high");
        rd(0, "R1 word intact");

        // R8/R9: output enable high on a read edge
        cyc(2, 36'h0, 0, 1, 0, 1, 1, 4'hF, 1, 0, "R8 R9 oe high");

        // R8: asynchronous toggle inside a read cycle
        rd(3, "R7 read before toggle");
        @(negedge clk); #1;
        out_en_n = 1; #1;
        check("R8 R9 async disable", 1'b0, 36'h0);
        out_en_n = 0; #1;
        check("R8 async enable", 1'b1, shadow[3]);

        // R10: sleep blocks writes and freezes state
        cyc(0, 36'h1_2121_2121, 0, 1, 0, 0, 0, 4'h0, 0, 1, "R10 sleep write");
        cyc(2, 36'h0, 0, 1, 0, 1, 1, 4'hF, 0, 1, "R10 sleep read");
        rd(0, "R10 contents retained");
        rd(3, "R7 final read");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule